// File: doc/BRIEF.md
# Main Control Decoder

This block turns the seven-bit major opcode of a fetched instruction into the steering signals of a single-cycle datapath. It is purely combinational. In the same cycle that the instruction word is read, it drives the register-file write enable, the choice between a register and an immediate for the second ALU operand, the write-back source, the data-memory read and write strobes, the conditional-branch and unconditional-jump flags, and a coarse two-bit ALU operation class. A separate unit turns that class into an exact ALU function.

The recognised classes are register-register arithmetic, register-immediate arithmetic, word load, word store, branch-if-equal and jump-and-link. Every output that the datapath would ignore for a class is driven to 0, so each opcode gives exactly one output pattern. Any other opcode is decoded as a bubble: nothing is written, memory is not touched, and the program counter simply advances by four.

Top module: `main_ctrl_decoder`

## Requirements
- R1: Opcode 7'b0110011 (register-register) gives reg_we_o=1, alu_b_imm_o=0, wb_sel_o=2'b00, mem_rd_o=0, mem_wr_o=0, branch_o=0, jump_o=0, alu_class_o=2'b10.
- R2: Opcode 7'b0010011 (register-immediate) gives reg_we_o=1, alu_b_imm_o=1, wb_sel_o=2'b00, no memory strobe, branch_o=0, jump_o=0, alu_class_o=2'b10.
- R3: Opcode 7'b0000011 (word load) gives reg_we_o=1, alu_b_imm_o=1, wb_sel_o=2'b01, mem_rd_o=1, mem_wr_o=0, branch_o=0, jump_o=0, alu_class_o=2'b00.
- R4: Opcode 7'b0100011 (word store) gives mem_wr_o=1, alu_b_imm_o=1, reg_we_o=0, mem_rd_o=0, wb_sel_o=2'b00 (unused, forced low), branch_o=0, jump_o=0, alu_class_o=2'b00.
- R5: Opcode 7'b1100011 (branch if equal) gives branch_o=1, alu_b_imm_o=0, reg_we_o=0, no memory strobe, wb_sel_o=2'b00 (unused, forced low), jump_o=0, alu_class_o=2'b01.
- R6: Opcode 7'b1101111 (jump and link) gives jump_o=1, reg_we_o=1, wb_sel_o=2'b10 (return address PC+4), alu_b_imm_o=0, no memory strobe, branch_o=0, alu_class_o=2'b00.
- R7: Every other opcode drives all outputs to 0.
- R8: mem_rd_o and mem_wr_o are never both 1, and branch_o and jump_o are never both 1.
- R9: wb_sel_o never takes the value 2'b11; the codes are 00 ALU result, 01 memory data, 10 PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 7 | Major opcode field of the current instruction |
| reg_we_o | output | 1 | Register-file write enable |
| alu_b_imm_o | output | 1 | Second ALU operand taken from the immediate |
| wb_sel_o | output | 2 | Write-back source: 00 ALU, 01 memory, 10 PC+4 |
| mem_rd_o | output | 1 | Data-memory read strobe |
| mem_wr_o | output | 1 | Data-memory write strobe |
| branch_o | output | 1 | Conditional branch on equality |
| jump_o | output | 1 | Unconditional jump |
| alu_class_o | output | 2 | ALU class: 00 add, 01 subtract, 10 by function field |

## Verification
Two actions must be raised together for a jump-and-link: the register write of the return address and the redirect of the program counter. A load likewise pairs a memory read with a register write. The bench sweeps all 128 opcode values and compares the whole output bundle against a model built from the requirements, so that a missing half of such a pair shows up as a miscompare on that opcode. Because the sweep also covers every unlisted value, an opcode that decodes a stray strobe is caught as well.

// File: rtl/main_ctrl_decoder.sv
module main_ctrl_decoder #(
  parameter int OPC_W = 7,
  parameter int WB_W  = 2,
  parameter int ALU_W = 2
) (
  input  logic [OPC_W-1:0] opcode_i,
  output logic             reg_we_o,
  output logic             alu_b_imm_o,
  output logic [WB_W-1:0]  wb_sel_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             branch_o,
  output logic             jump_o,
  output logic [ALU_W-1:0] alu_class_o
);

  localparam logic [OPC_W-1:0] OP_RR   = OPC_W'(7'b0110011);
  localparam logic [OPC_W-1:0] OP_RI   = OPC_W'(7'b0010011);
  localparam logic [OPC_W-1:0] OP_LD   = OPC_W'(7'b0000011);
  localparam logic [OPC_W-1:0] OP_ST   = OPC_W'(7'b0100011);
  localparam logic [OPC_W-1:0] OP_BEQ  = OPC_W'(7'b1100011);
  localparam logic [OPC_W-1:0] OP_JAL  = OPC_W'(7'b1101111);

  localparam logic [WB_W-1:0]  WB_ALU  = WB_W'(0);
  localparam logic [WB_W-1:0]  WB_MEM  = WB_W'(1);
  localparam logic [WB_W-1:0]  WB_LINK = WB_W'(2);

  localparam logic [ALU_W-1:0] CL_ADD  = ALU_W'(0);
  localparam logic [ALU_W-1:0] CL_SUB  = ALU_W'(1);
  localparam logic [ALU_W-1:0] CL_FN   = ALU_W'(2);

  always_comb begin
    reg_we_o    = 1'b0;
    alu_b_imm_o = 1'b0;
    wb_sel_o    = WB_ALU;
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    branch_o    = 1'b0;
    jump_o      = 1'b0;
    alu_class_o = CL_ADD;
    case (opcode_i)
      OP_RR: begin
        reg_we_o    = 1'b1;
        alu_class_o = CL_FN;
      end
      OP_RI: begin
        reg_we_o    = 1'b1;
        alu_b_imm_o = 1'b1;
        alu_class_o = CL_FN;
      end
      OP_LD: begin
        reg_we_o    = 1'b1;
        alu_b_imm_o = 1'b1;
        wb_sel_o    = WB_MEM;
        mem_rd_o    = 1'b1;
      end
      OP_ST: begin
        alu_b_imm_o = 1'b1;
        mem_wr_o    = 1'b1;
      end
      OP_BEQ: begin
        branch_o    = 1'b1;
        alu_class_o = CL_SUB;
      end
      OP_JAL: begin
        reg_we_o    = 1'b1;
        jump_o      = 1'b1;
        wb_sel_o    = WB_LINK;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown(opcode_i)) begin
      a_r8_mem_strobes_exclusive: assert (!(mem_rd_o && mem_wr_o));
      a_r8_redirect_exclusive: assert (!(branch_o && jump_o));
      a_r9_wb_code_legal: assert (wb_sel_o != 2'b11);
      a_r6_jump_links_pc4: assert (!jump_o || (reg_we_o && wb_sel_o == WB_LINK));
      a_r3_mem_data_needs_read: assert ((wb_sel_o != WB_MEM) || mem_rd_o);
      a_r4_store_no_regwrite: assert (!mem_wr_o || !reg_we_o);
      a_r5_branch_no_regwrite: assert (!branch_o || !reg_we_o);
    end
  end

endmodule

// File: tb/main_ctrl_decoder_bench.sv
`timescale 1ns/1ps
module main_ctrl_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] opcode;
  logic       we, bimm, mrd, mwr, br, jmp;
  logic [1:0] wb, cls;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  main_ctrl_decoder u_main_ctrl_decoder (
    .opcode_i(opcode), .reg_we_o(we), .alu_b_imm_o(bimm), .wb_sel_o(wb),
    .mem_rd_o(mrd), .mem_wr_o(mwr), .branch_o(br), .jump_o(jmp), .alu_class_o(cls)
  );

  // bundle order: we, bimm, wb[1:0], mrd, mwr, br, jmp, cls[1:0]
  function automatic logic [9:0] model(input logic [6:0] op, output string tag);
    case (op)
      7'b0110011: begin tag = "R1"; return {1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,2'b10}; end
      7'b0010011: begin tag = "R2"; return {1'b1,1'b1,2'b00,1'b0,1'b0,1'b0,1'b0,2'b10}; end
      7'b0000011: begin tag = "R3"; return {1'b1,1'b1,2'b01,1'b1,1'b0,1'b0,1'b0,2'b00}; end
      7'b0100011: begin tag = "R4"; return {1'b0,1'b1,2'b00,1'b0,1'b1,1'b0,1'b0,2'b00}; end
      7'b1100011: begin tag = "R5"; return {1'b0,1'b0,2'b00,1'b0,1'b0,1'b1,1'b0,2'b01}; end
      7'b1101111: begin tag = "R6"; return {1'b1,1'b0,2'b10,1'b0,1'b0,1'b0,1'b1,2'b00}; end
      default:    begin tag = "R7"; return 10'b0; end
    endcase
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp, input logic [6:0] op);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s opcode=%b actual=%b expected=%b", tag, op, act, exp);
    end
  endtask

  initial begin
    string tag;
    logic [9:0] exp;
    logic [9:0] act;
    opcode = 7'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // state after reset with an all-zero opcode: quiet (R7)
    check("R7", {we,bimm,wb,mrd,mwr,br,jmp,cls}, 10'b0, opcode);
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      opcode = 7'(i);
      #2;
      exp = model(opcode, tag);
      act = {we,bimm,wb,mrd,mwr,br,jmp,cls};
      check(tag, act, exp, opcode);
      // R8 / R9 at the ports for every opcode
      check("R8", {8'b0, mrd & mwr, br & jmp}, 10'b0, opcode);
      check("R9", {9'b0, wb == 2'b11}, 10'b0, opcode);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule